// File: doc/BRIEF.md
# Dual-Source Reset and I/O-Width Controller

This block produces the internal reset strobes of a bus-attached network controller from two sources. The first source is an asynchronous, active-low hardware reset pin. The pin is synchronized into the core clock and counted, so a glitch that is shorter than the minimum width has no effect. A qualified hardware reset fires when the pin is released. It pulses every reset target and asks the serial configuration memory to load.

The second source is a host read of the reset register, which gives a software reset. The offset of that register depends on the current I/O width. A software reset restarts only the control registers and the sequencer. It also forces the bus-master request low and leaves configuration space, link state and the memory load untouched.

The block holds the doubleword-I/O mode bit. The bit is set by a doubleword write to the data port and cleared by either kind of reset. After any reset, a flag tells the host that it must re-initialize the controller. All host signals are single-cycle pulses with no back-pressure. Every access is taken in the cycle it is presented, so the block has no ready signal.

Top module: `dual_reset_ctrl`

## Requirements
- R1: A hardware reset pin that is held low for fewer than MIN_PULSE core clock cycles causes no strobe, no memory-load request and no change of the I/O mode bit.
- R2: A pin that is held low for at least MIN_PULSE cycles gives, after its release, one pulse each on `ctl_regs_rst`, `cfg_space_rst`, `seq_rst`, `link_fail_set` and `cfgmem_load_req`, all in the same cycle.
- R3: A host read at offset 0x14 while `io_dword_mode` is 0, or at offset 0x18 while it is 1, triggers a software reset. Reads at other offsets and writes at any offset trigger none.
- R4: A software reset pulses `ctl_regs_rst` and `seq_rst` in the cycle after the read. It does not pulse `cfg_space_rst`, `link_fail_set` or `cfgmem_load_req`.
- R5: A host write with `host_dword`=1 at offset 0x10 sets `io_dword_mode` to 1 from the next cycle. A write at 0x10 with `host_dword`=0 leaves the bit unchanged.
- R6: A software reset and a qualified hardware reset both clear `io_dword_mode` to 0, which is 16-bit I/O mode.
- R7: `bus_req_out` is 0 in three cases: during the triggering read cycle, during the software-reset strobe cycle, and while the synchronized reset pin is asserted. Otherwise it follows `bus_req_in`.
- R8: A reset-register read that arrives while the synchronized hardware reset pin is asserted is ignored.
- R9: `reinit_needed` becomes 1 in the cycle after any reset strobe. It returns to 0 only after a `host_reinit` pulse that comes with no strobe.
- R10: Every hardware reset strobe is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core-domain power-up reset, active low |
| hw_rst_pin_n | input | 1 | Asynchronous hardware reset pin, active low |
| host_rd | input | 1 | Host read access pulse |
| host_wr | input | 1 | Host write access pulse |
| host_dword | input | 1 | Access is 32 bits wide |
| host_addr | input | ADDR_W | Register offset of the access |
| host_reinit | input | 1 | Host has completed re-initialization |
| bus_req_in | input | 1 | Bus-master request from the DMA logic |
| bus_req_out | output | 1 | Bus-master request toward the bus |
| ctl_regs_rst | output | 1 | Control-register reset strobe |
| cfg_space_rst | output | 1 | Configuration-space reset strobe |
| seq_rst | output | 1 | Sequencer reset strobe |
| link_fail_set | output | 1 | Forces link-integrity logic to link-fail |
| cfgmem_load_req | output | 1 | Request to load the serial configuration memory |
| io_dword_mode | output | 1 | 1 = 32-bit I/O mode, 0 = 16-bit |
| reinit_needed | output | 1 | Host must re-initialize |

## Verification
A table of host accesses covers the following cases:
- reads at the word and doubleword reset offsets in both I/O modes;
- word and doubleword writes to the data port;
- writes to the reset offsets.

These cases separate a correct width-dependent decode from one that ignores the mode or that also reacts to writes. Hardware pin pulses one cycle short of the minimum and exactly at the minimum probe the boundary of the width counter. A reset-register read issued inside a long pin pulse shows whether a software reset leaks through during a hardware reset. Counting the pulses on each strobe separates the two reset types by which targets they reach.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_RST_WORD  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RST_DWORD = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_DATA_PORT = 8'h10;

  // Offset of the reset register under the current I/O width
  function automatic logic [ADDR_W-1:0] rst_offset(input logic dword_mode);
    return dword_mode ? OFS_RST_DWORD : OFS_RST_WORD;
  endfunction
endpackage

// File: rtl/rstctl_pin_qual.sv
module rstctl_pin_qual #(
  parameter int MIN_PULSE = 8
) (
  input  logic clk,
  input  logic core_rst_n,
  input  logic pin_n,
  output logic hw_busy,
  output logic hw_fire
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] CNT_ARM = CW'(MIN_PULSE - 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(MIN_PULSE);

  logic sync1_n, sync2_n;
  logic asserted;
  logic [CW-1:0] cnt;
  logic armed;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sync1_n <= 1'b1;
      sync2_n <= 1'b1;
    end else begin
      sync1_n <= pin_n;
      sync2_n <= sync1_n;
    end
  end

  assign asserted = ~sync2_n;
  assign hw_busy  = asserted;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      hw_fire <= 1'b0;
    end else begin
      hw_fire <= armed & ~asserted;
      if (!asserted) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        if (cnt == CNT_ARM) armed <= 1'b1;
      end
    end
  end

  // R10
  hw_fire_single_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    hw_fire |=> !hw_fire);
  // R1
  arm_needs_width_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(armed) |-> cnt == CNT_SAT);
endmodule

// File: rtl/rstctl_host_dec.sv
module rstctl_host_dec
  import rstctl_pkg::*;
(
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic              dword,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hw_busy,
  input  logic              hw_fire,
  output logic              sw_hit,
  output logic              sw_strobe,
  output logic              dword_mode
);
  logic width_set;

  assign sw_hit    = rd & ~hw_busy & (addr == rst_offset(dword_mode));
  assign width_set = wr & dword & (addr == OFS_DATA_PORT);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sw_strobe  <= 1'b0;
      dword_mode <= 1'b0;
    end else begin
      sw_strobe <= sw_hit;
      if (sw_hit || hw_fire)  dword_mode <= 1'b0;
      else if (width_set)     dword_mode <= 1'b1;
    end
  end

  // R5
  width_set_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr && dword && addr == OFS_DATA_PORT && !rd && !hw_fire) |=> dword_mode);
  // R6
  width_clear_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sw_hit || hw_fire) |=> !dword_mode);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    hw_busy |=> !sw_strobe);
endmodule

// File: rtl/dual_reset_ctrl.sv
module dual_reset_ctrl
  import rstctl_pkg::*;
#(
  parameter int MIN_PULSE = 8
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              hw_rst_pin_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_dword,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_reinit,
  input  logic              bus_req_in,
  output logic              bus_req_out,
  output logic              ctl_regs_rst,
  output logic              cfg_space_rst,
  output logic              seq_rst,
  output logic              link_fail_set,
  output logic              cfgmem_load_req,
  output logic              io_dword_mode,
  output logic              reinit_needed
);
  logic hw_busy, hw_fire, sw_hit, sw_strobe;

  rstctl_pin_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .core_rst_n(core_rst_n), .pin_n(hw_rst_pin_n),
    .hw_busy(hw_busy), .hw_fire(hw_fire)
  );

  rstctl_host_dec u_dec (
    .clk(clk), .core_rst_n(core_rst_n), .rd(host_rd), .wr(host_wr),
    .dword(host_dword), .addr(host_addr), .hw_busy(hw_busy), .hw_fire(hw_fire),
    .sw_hit(sw_hit), .sw_strobe(sw_strobe), .dword_mode(io_dword_mode)
  );

  assign ctl_regs_rst    = hw_fire | sw_strobe;
  assign seq_rst         = hw_fire | sw_strobe;
  assign cfg_space_rst   = hw_fire;
  assign link_fail_set   = hw_fire;
  assign cfgmem_load_req = hw_fire;
  assign bus_req_out     = bus_req_in & ~(sw_hit | sw_strobe | hw_busy);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)                reinit_needed <= 1'b0;
    else if (hw_fire || sw_strobe)  reinit_needed <= 1'b1;
    else if (host_reinit)           reinit_needed <= 1'b0;
  end

  // R9
  reinit_set_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    seq_rst |=> reinit_needed);
  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sw_strobe || hw_busy) |-> !bus_req_out);
  // R4
  sw_scope_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctl_regs_rst && !cfgmem_load_req) |-> (!cfg_space_rst && !link_fail_set));
endmodule

// File: tb/dual_reset_ctrl_tb_top.sv
module dual_reset_ctrl_tb_top;
  localparam int MINP = 8;

  logic clk = 1'b0;
  logic core_rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic rd = 0, wr = 0, dw = 0, reinit = 0, req_in = 1'b1;
  logic [7:0] addr = '0;
  logic req_out, ctl_rst, cfg_rst, sq_rst, lnk, ld_req, dwio, rin;

  int n_chk = 0, n_err = 0;
  int c_ctl = 0, c_cfg = 0, c_seq = 0, c_lnk = 0, c_ld = 0, wide_cfg = 0;
  logic prev_cfg = 1'b0;

  always #5 clk = ~clk;

  dual_reset_ctrl #(.MIN_PULSE(MINP)) dut_i (
    .clk(clk), .core_rst_n(core_rst_n), .hw_rst_pin_n(pin_n),
    .host_rd(rd), .host_wr(wr), .host_dword(dw), .host_addr(addr),
    .host_reinit(reinit), .bus_req_in(req_in), .bus_req_out(req_out),
    .ctl_regs_rst(ctl_rst), .cfg_space_rst(cfg_rst), .seq_rst(sq_rst),
    .link_fail_set(lnk), .cfgmem_load_req(ld_req),
    .io_dword_mode(dwio), .reinit_needed(rin)
  );

  always @(negedge clk) begin
    if (ctl_rst) c_ctl++;
    if (cfg_rst) c_cfg++;
    if (sq_rst)  c_seq++;
    if (lnk)     c_lnk++;
    if (ld_req)  c_ld++;
    if (cfg_rst && prev_cfg) wide_cfg++;
    prev_cfg = cfg_rst;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {is_wr, dword, addr[7:0], expect_sw_reset, expect_dwio_after}
  localparam logic [11:0] VEC [10] = '{
    {1'b0, 1'b0, 8'h14, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h18, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h10, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h14, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h10, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h18, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h14, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h10, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h18, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h18, 1'b1, 1'b0}
  };

  task automatic pin_pulse(input int len, input bit mid_read);
    @(negedge clk);
    pin_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (mid_read && i == 5) begin
        rd = 1'b1; addr = dwio ? 8'h18 : 8'h14;
        #1 check("R7 req low during hw reset", req_out, 0);
      end
      @(negedge clk);
      rd = 1'b0;
    end
    pin_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int b_ctl, b_cfg, b_seq, b_lnk, b_ld;
    repeat (3) @(negedge clk);
    core_rst_n = 1'b1;
    @(negedge clk);
    check("reset ctl_regs_rst", ctl_rst, 0);
    check("reset dwio", dwio, 0);
    check("reset reinit", rin, 0);
    check("R7 req follows", req_out, 1);

    foreach (VEC[k]) begin
      @(negedge clk);
      wr = VEC[k][11]; rd = ~VEC[k][11]; dw = VEC[k][10]; addr = VEC[k][9:2];
      #1 check($sformatf("R7 req in access v%0d", k), req_out, !VEC[k][1]);
      @(negedge clk);
      rd = 0; wr = 0; dw = 0;
      check($sformatf("R3 ctl strobe v%0d", k), ctl_rst, VEC[k][1]);
      check($sformatf("R4 seq strobe v%0d", k), sq_rst, VEC[k][1]);
      check($sformatf("R4 no cfg v%0d", k), cfg_rst | lnk | ld_req, 0);
      check($sformatf("R5 R6 dwio v%0d", k), dwio, VEC[k][0]);
      if (VEC[k][1]) check($sformatf("R7 req in strobe v%0d", k), req_out, 0);
      @(negedge clk);
      check($sformatf("R3 strobe ends v%0d", k), ctl_rst, 0);
    end

    check("R9 reinit after sw", rin, 1);
    reinit = 1; @(negedge clk); reinit = 0;
    check("R9 reinit cleared", rin, 0);

    // set dword mode, then short pulse must not touch it
    wr = 1; dw = 1; addr = 8'h10; @(negedge clk); wr = 0; dw = 0;
    b_cfg = c_cfg; b_ctl = c_ctl; b_ld = c_ld;
    pin_pulse(MINP - 1, 1'b0);
    check("R1 short pulse cfg", c_cfg - b_cfg, 0);
    check("R1 short pulse ctl", c_ctl - b_ctl, 0);
    check("R1 short pulse load", c_ld - b_ld, 0);
    check("R1 short pulse dwio", dwio, 1);
    check("R1 reinit stays", rin, 0);

    b_ctl = c_ctl; b_cfg = c_cfg; b_seq = c_seq; b_lnk = c_lnk; b_ld = c_ld;
    pin_pulse(MINP + 4, 1'b1);
    check("R2 cfg pulses", c_cfg - b_cfg, 1);
    check("R2 link pulses", c_lnk - b_lnk, 1);
    check("R2 load pulses", c_ld - b_ld, 1);
    check("R8 ctl pulses only hw", c_ctl - b_ctl, 1);
    check("R8 seq pulses only hw", c_seq - b_seq, 1);
    check("R6 dwio after hw", dwio, 0);
    check("R9 reinit after hw", rin, 1);
    check("R10 cfg width", wide_cfg, 0);

    b_cfg = c_cfg;
    pin_pulse(MINP, 1'b0);
    check("R2 min width qualifies", c_cfg - b_cfg, 1);
    check("R7 req restored", req_out, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule